// File: doc/BRIEF.md
# Framed SPI Register Target for a Four-Channel Switch Controller

This block is the configuration port of a multi-channel PWM switch controller. An external host talks to it over a four-wire SPI link in which chip select frames each 16-bit word on its own. The upper byte of a word carries the register address and the lower byte carries data. Address bit 7 turns the word into a register write. With that bit clear, bit 7 of the data byte asks for a read, and the register value comes back on MISO during the following word. A host that wants several registers sends several words, each framed by its own chip select pulse.

The block holds the controller's register file: the global mode, the per-channel polarity bits, the per-channel enables, a frequency byte and a duty byte per channel, and a watchdog byte. These registers drive the PWM generator next to it. A channel's run output is held low unless the global mode field selects normal operation. All three SPI inputs are brought into the system clock domain through two-flop synchronisers. The frame engine is a four-state machine:
- `FS_IDLE` waits for chip select to fall (transition *start*: go to `FS_SHIFT`, clear the bit count, load the response shifter).
- `FS_SHIFT` takes one bit on each rising SCLK. *abort*: chip select rises early, back to `FS_IDLE`. *fill*: the 16th rising edge arrives, go to `FS_FULL`.
- `FS_FULL` holds a complete word. *commit*: chip select rises, back to `FS_IDLE` with a one-cycle commit pulse. *overrun*: a 17th rising edge arrives, go to `FS_SPILL`.
- `FS_SPILL` discards the word. *drop*: chip select rises, back to `FS_IDLE`.

Top module: `spirs_top`

## Requirements
- R1: A word is committed only when chip select rises after exactly 16 rising SCLK edges (SPI mode 0, MSB first). Bits [15:8] are the address byte and bits [7:0] are the data byte.
- R2: When frame bit 15 (address bit 7) is 1, the data byte is written to the register at address bits [6:0]. This holds even when data bit 7 is also 1.
- R3: When frame bit 15 is 0 and data bit 7 is 1, the addressed register byte is shifted out MSB first on MISO during the next framed word. It is placed in bits [7:0] of the 14-bit data field [13:0], with all upper bits zero. MISO changes only on falling SCLK and at the start of a frame.
- R4: A committed word that does not request a read makes the next word's MISO response all zeros.
- R5: A word ended by chip select before 16 rising edges, or one that receives more than 16 rising edges, changes no register and leaves the pending response unchanged.
- R6: The register addresses are fixed. 0x00 holds the global mode in bits [7:6], where 01 means normal. 0x05 holds the polarity of channel n in bit n-1. 0x07 holds the enable of channel n in bit n+3. 0x08+n-1 holds the frequency of channel n and 0x0C+n-1 its duty. 0x14 is the watchdog byte. Every register stores and returns all 8 bits.
- R7: A write to any other address is ignored, and a read of any other address returns zero.
- R8: The run output of channel n equals its enable bit while the mode field is 01, and is 0 otherwise.
- R9: After reset every register is zero, the pending response is zero and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low, one pulse per word |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| glb_mode | output | 2 | Global mode field |
| ch_pol | output | 4 | Polarity per channel, bit 0 is channel 1 |
| ch_run | output | 4 | Gated enable per channel |
| ch_freq | output | 32 | Frequency bytes, channel 1 in bits [7:0] |
| ch_duty | output | 32 | Duty bytes, channel 1 in bits [7:0] |
| wdt_val | output | 8 | Watchdog register |

## Verification
The hardest case to reach from the ports is a word that is clocked fully but must still be thrown away. One version is a 17-edge word, which passes through the full state and on to the discard state. The other is a word cut short after a read request, where the response owed from the earlier word must survive the aborted word and still appear on the next one. The stimulus sets up a read, sends a truncated write and an over-long write aimed at the same register, and then sends a clean word. The MISO bits of that clean word are compared with the response the reference model kept from before the aborted words. The per-clock output comparison also shows that the target register never moved.

// File: rtl/spirs_pkg.sv
package spirs_pkg;
    localparam int unsigned FRAME_W    = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned RESP_W     = 14;
    localparam int unsigned MODE_LSB   = 6;
    localparam int unsigned ENA_LSB    = 4;
    localparam logic [1:0]  MODE_NORMAL = 2'b01;

    localparam logic [ADDR_W-1:0] ADDR_GLB   = 7'h00;
    localparam logic [ADDR_W-1:0] ADDR_POL   = 7'h05;
    localparam logic [ADDR_W-1:0] ADDR_ENA   = 7'h07;
    localparam logic [ADDR_W-1:0] ADDR_FREQ0 = 7'h08;
    localparam logic [ADDR_W-1:0] ADDR_DUTY0 = 7'h0C;
    localparam logic [ADDR_W-1:0] ADDR_WDT   = 7'h14;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SHIFT = 2'd1,
        FS_FULL  = 2'd2,
        FS_SPILL = 2'd3
    } frame_st_e;

    typedef struct packed {
        logic                 wr;
        logic [ADDR_W-1:0]    addr;
        logic                 rd;
        logic [BYTE_W-2:0]    low;
    } cmd_t;
endpackage

// File: rtl/spirs_sync.sv
module spirs_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spirs_frame.sv
module spirs_frame
    import spirs_pkg::*;
#(
    parameter int unsigned FW = FRAME_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk_s,
    input  logic                      cs_n_s,
    input  logic                      mosi_s,
    input  logic [FW-1:0]             resp,
    output logic                      miso,
    output logic                      commit,
    output logic [FW-1:0]             word,
    output frame_st_e                 st,
    output logic [$clog2(FW+1)-1:0]   bit_cnt,
    output logic                      sclk_fall,
    output logic                      cs_fall
);
    localparam int unsigned CW = $clog2(FW + 1);
    localparam logic [CW-1:0] LAST = CW'(FW - 1);

    frame_st_e nx;
    logic sclk_q, cs_q;
    logic sclk_rise, cs_rise;
    logic [FW-1:0] rx_sh, tx_sh;

    // edge detection on the synchronised lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = cs_n_s & ~cs_q;
    assign cs_fall   = ~cs_n_s & cs_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_IDLE;
        else        st <= nx;
    end

    // next state
    always_comb begin
        nx = st;
        unique case (st)
            FS_IDLE:  if (cs_fall) nx = FS_SHIFT;
            FS_SHIFT: begin
                if (cs_rise)                           nx = FS_IDLE;
                else if (sclk_rise && bit_cnt == LAST) nx = FS_FULL;
            end
            FS_FULL: begin
                if (cs_rise)        nx = FS_IDLE;
                else if (sclk_rise) nx = FS_SPILL;
            end
            FS_SPILL: if (cs_rise) nx = FS_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            if (st == FS_IDLE && cs_fall) begin
                bit_cnt <= '0;
                tx_sh   <= resp;
            end else if (st != FS_IDLE && !cs_rise) begin
                if (st == FS_SHIFT && sclk_rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    rx_sh   <= {rx_sh[FW-2:0], mosi_s};
                end
                if (sclk_fall) tx_sh <= {tx_sh[FW-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit <= 1'b0;
            word   <= '0;
        end else begin
            commit <= (st == FS_FULL) && cs_rise;
            if ((st == FS_FULL) && cs_rise) word <= rx_sh;
        end
    end

    assign miso = tx_sh[FW-1];
endmodule

// File: rtl/spirs_regs.sv
module spirs_regs
    import spirs_pkg::*;
#(
    parameter int unsigned N_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [FRAME_W-1:0]    word,
    output logic [FRAME_W-1:0]    resp,
    output logic [1:0]            glb_mode,
    output logic [N_CH-1:0]       ch_pol,
    output logic [N_CH-1:0]       ch_run,
    output logic [N_CH*BYTE_W-1:0] ch_freq,
    output logic [N_CH*BYTE_W-1:0] ch_duty,
    output logic [BYTE_W-1:0]     wdt_val
);
    localparam int unsigned PAD_W = FRAME_W - BYTE_W;

    cmd_t cmd;
    logic [BYTE_W-1:0] data;
    logic              we;
    logic [BYTE_W-1:0] rd_byte;

    logic [BYTE_W-1:0] glb_r, pol_r, ena_r, wdt_r;
    logic [BYTE_W-1:0] freq_r [N_CH];
    logic [BYTE_W-1:0] duty_r [N_CH];

    assign cmd  = cmd_t'(word);
    assign data = word[BYTE_W-1:0];
    assign we   = commit & cmd.wr;

    // scalar registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_r <= '0;
            pol_r <= '0;
            ena_r <= '0;
            wdt_r <= '0;
        end else if (we) begin
            if (cmd.addr == ADDR_GLB) glb_r <= data;
            if (cmd.addr == ADDR_POL) pol_r <= data;
            if (cmd.addr == ADDR_ENA) ena_r <= data;
            if (cmd.addr == ADDR_WDT) wdt_r <= data;
        end
    end

    // per-channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) begin
                freq_r[i] <= '0;
                duty_r[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < N_CH; i++) begin
                if (cmd.addr == ADDR_FREQ0 + ADDR_W'(i)) freq_r[i] <= data;
                if (cmd.addr == ADDR_DUTY0 + ADDR_W'(i)) duty_r[i] <= data;
            end
        end
    end

    // read selection
    always_comb begin
        rd_byte = '0;
        if (cmd.addr == ADDR_GLB) rd_byte = glb_r;
        if (cmd.addr == ADDR_POL) rd_byte = pol_r;
        if (cmd.addr == ADDR_ENA) rd_byte = ena_r;
        if (cmd.addr == ADDR_WDT) rd_byte = wdt_r;
        for (int i = 0; i < N_CH; i++) begin
            if (cmd.addr == ADDR_FREQ0 + ADDR_W'(i)) rd_byte = freq_r[i];
            if (cmd.addr == ADDR_DUTY0 + ADDR_W'(i)) rd_byte = duty_r[i];
        end
    end

    // response for the next frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      resp <= '0;
        else if (commit) resp <= (!cmd.wr && cmd.rd) ? {{PAD_W{1'b0}}, rd_byte} : '0;
    end

    assign glb_mode = glb_r[MODE_LSB +: 2];
    assign ch_pol   = pol_r[N_CH-1:0];
    assign ch_run   = ena_r[ENA_LSB +: N_CH] & {N_CH{glb_mode == MODE_NORMAL}};
    assign wdt_val  = wdt_r;

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_out
            assign ch_freq[g*BYTE_W +: BYTE_W] = freq_r[g];
            assign ch_duty[g*BYTE_W +: BYTE_W] = duty_r[g];
        end
    endgenerate
endmodule

// File: rtl/spirs_top.sv
module spirs_top
    import spirs_pkg::*;
#(
    parameter int unsigned N_CH        = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk,
    input  logic                    cs_n,
    input  logic                    mosi,
    output logic                    miso,
    output logic [1:0]              glb_mode,
    output logic [N_CH-1:0]         ch_pol,
    output logic [N_CH-1:0]         ch_run,
    output logic [N_CH*BYTE_W-1:0]  ch_freq,
    output logic [N_CH*BYTE_W-1:0]  ch_duty,
    output logic [BYTE_W-1:0]       wdt_val
);
    localparam int unsigned CW = $clog2(FRAME_W + 1);

    logic [2:0]         sync_q;
    logic               sclk_s, cs_n_s, mosi_s;
    logic               commit;
    logic [FRAME_W-1:0] word, resp;
    frame_st_e          fsm_st;
    logic [CW-1:0]      bit_cnt;
    logic               sclk_fall, cs_fall;

    spirs_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs_n, mosi}),
        .q    (sync_q)
    );

    assign {sclk_s, cs_n_s, mosi_s} = sync_q;

    spirs_frame #(.FW(FRAME_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .resp     (resp),
        .miso     (miso),
        .commit   (commit),
        .word     (word),
        .st       (fsm_st),
        .bit_cnt  (bit_cnt),
        .sclk_fall(sclk_fall),
        .cs_fall  (cs_fall)
    );

    spirs_regs #(.N_CH(N_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .word    (word),
        .resp    (resp),
        .glb_mode(glb_mode),
        .ch_pol  (ch_pol),
        .ch_run  (ch_run),
        .ch_freq (ch_freq),
        .ch_duty (ch_duty),
        .wdt_val (wdt_val)
    );
endmodule

// File: rtl/spirs_chk.sv
module spirs_chk
    import spirs_pkg::*;
#(
    parameter int unsigned N_CH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input frame_st_e               fsm_st,
    input logic [$clog2(FRAME_W+1)-1:0] bit_cnt,
    input logic                    commit,
    input logic [FRAME_W-1:0]      word,
    input logic [FRAME_W-1:0]      resp,
    input logic                    miso,
    input logic                    sclk_fall,
    input logic                    cs_fall,
    input logic [1:0]              glb_mode,
    input logic [N_CH-1:0]         ch_pol,
    input logic [N_CH-1:0]         ch_run,
    input logic [N_CH*BYTE_W-1:0]  ch_freq,
    input logic [N_CH*BYTE_W-1:0]  ch_duty,
    input logic [BYTE_W-1:0]       wdt_val
);
    // R1: a commit only follows a full word
    a_r1_commit_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(fsm_st) == FS_FULL && $past(bit_cnt) == FRAME_W));

    // R1: bit count never exceeds the frame width
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FRAME_W);

    // R5: no register moves without a committed word
    a_r5_quiet_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ch_freq) && $stable(ch_duty) && $stable(ch_pol)
                     && $stable(wdt_val) && $stable(glb_mode)));

    // R5: pending response held between commits
    a_r5_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(resp));

    // R4: non-read word clears the response
    a_r4_zero_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (word[15] || !word[7])) |=> (resp == '0));

    // R8: run outputs low outside normal mode
    a_r8_run_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_mode != MODE_NORMAL) |-> (ch_run == '0));

    // R3: MISO moves only after a falling clock or frame start
    a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sclk_fall || cs_fall));
endmodule

bind spirs_top spirs_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsm_st   (fsm_st),
    .bit_cnt  (bit_cnt),
    .commit   (commit),
    .word     (word),
    .resp     (resp),
    .miso     (miso),
    .sclk_fall(sclk_fall),
    .cs_fall  (cs_fall),
    .glb_mode (glb_mode),
    .ch_pol   (ch_pol),
    .ch_run   (ch_run),
    .ch_freq  (ch_freq),
    .ch_duty  (ch_duty),
    .wdt_val  (wdt_val)
);

// File: tb/tb_spirs_top.sv
module tb_spirs_top;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [1:0]  glb_mode;
    logic [3:0]  ch_pol, ch_run;
    logic [31:0] ch_freq, ch_duty;
    logic [7:0]  wdt_val;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    logic [7:0]  mdl [0:127];
    logic [15:0] exp_resp = 16'h0;

    always #5 clk = ~clk;

    spirs_top dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .glb_mode(glb_mode), .ch_pol(ch_pol), .ch_run(ch_run),
        .ch_freq(ch_freq), .ch_duty(ch_duty), .wdt_val(wdt_val)
    );

    function automatic bit mapped(input logic [6:0] a);
        return (a == 7'h00) || (a == 7'h05) || (a == 7'h07) || (a == 7'h14)
            || (a >= 7'h08 && a <= 7'h0F);
    endfunction

    function automatic logic [127:0] expected_outs();
        logic [1:0] m;
        logic [3:0] run;
        m   = mdl[0][7:6];
        run = (m == 2'b01) ? mdl[7][7:4] : 4'h0;
        return {m, mdl[5][3:0], run, mdl[20],
                mdl[11], mdl[10], mdl[9], mdl[8],
                mdl[15], mdl[14], mdl[13], mdl[12]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_commit(input logic [15:0] w);
        logic [6:0] a;
        a = w[14:8];
        if (w[15]) begin
            if (mapped(a)) mdl[a] = w[7:0];
            exp_resp = 16'h0;
        end else if (w[7]) begin
            exp_resp = mapped(a) ? {8'h00, mdl[a]} : 16'h0;
        end else begin
            exp_resp = 16'h0;
        end
    endtask

    // every-clock comparison of register outputs against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [127:0] act;
            act = {glb_mode, ch_pol, ch_run, wdt_val, ch_freq, ch_duty};
            check(act == expected_outs(), "R2/R6/R7/R8 outputs", act, expected_outs());
        end
    end

    task automatic xfer(input logic [15:0] w, input int nbits, input string tag);
        logic [15:0] got;
        got = 16'h0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (H) @(negedge clk);
            if (i < 16) got[15-i] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        cmp_on = 1'b0;
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
        if (nbits == 16) begin
            check(got == exp_resp, tag, {112'h0, got}, {112'h0, exp_resp});
            model_commit(w);
        end
        cmp_on = 1'b1;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected<=150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(miso == 1'b0, "R9 miso after reset", {127'h0, miso}, 128'h0);
        cmp_on = 1'b1;
        xfer(16'h1480, 16, "R9 first response zero");
        xfer(16'h0080, 16, "R9 read of reset register");
        xfer(16'h0000, 16, "R3 response of reset global");
        // R2/R6: writes across the map
        xfer(16'h8040, 16, "R4 response after read-nothing");
        xfer(16'h87F0, 16, "R4 after write");
        xfer(16'h8505, 16, "R4 after write");
        for (int c = 0; c < 4; c++) begin
            xfer({1'b1, 7'(8 + c), 8'(8'h11 * (c + 1))}, 16, "R2 freq write");
            xfer({1'b1, 7'(12 + c), 8'(8'hA0 + c)}, 16, "R2 duty write");
        end
        xfer(16'h945A, 16, "R2 wdt write");
        // R3: reads come back one word later
        xfer(16'h0880, 16, "R4 after write");
        xfer(16'h1480, 16, "R3 freq ch1 readback");
        xfer(16'h0F80, 16, "R3 wdt readback");
        xfer(16'h0780, 16, "R3 duty ch4 readback");
        xfer(16'h0080, 16, "R3 enable readback");
        xfer(16'h0500, 16, "R3 global readback");
        // R4: data bit 7 clear is not a read
        xfer(16'h0000, 16, "R4 no-read word gives zero");
        // R2: write with data bit 7 set is a write
        xfer(16'h8C80, 16, "R4 zero response");
        xfer(16'h0C80, 16, "R4 after write with bit7");
        xfer(16'h0000, 16, "R2 duty ch1 holds 0x80");
        // R7: unmapped addresses
        xfer(16'h8133, 16, "R4 zero response");
        xfer(16'h0180, 16, "R4 after unmapped write");
        xfer(16'h7F80, 16, "R7 unmapped read zero");
        xfer(16'h0000, 16, "R7 unmapped read zero");
        // R5: aborted and over-long words
        xfer(16'h0980, 16, "R4 zero response");
        xfer(16'h89FF, 10, "R5 short");
        xfer(16'h89EE, 17, "R5 long");
        xfer(16'h0980, 16, "R5 response survives aborted words");
        xfer(16'h0000, 16, "R5 register unchanged after aborts");
        // R8: mode gating
        xfer(16'h8080, 16, "R4 zero response");
        xfer(16'h80C0, 16, "R4 zero response");
        xfer(16'h8000, 16, "R4 zero response");
        xfer(16'h8040, 16, "R4 zero response");
        xfer(16'h8730, 16, "R4 zero response");
        xfer(16'h0780, 16, "R4 zero response");
        xfer(16'h0000, 16, "R3 enable readback 0x30");
        repeat (10) @(negedge clk);
        // R8: explicit port check
        check(ch_run == 4'b0011, "R8 run follows enable", {124'h0, ch_run}, {124'h0, 4'b0011});
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule